// File: doc/BRIEF.md
# Timer with variable-width PWM

This block is a 16-bit counter built from two byte-wide halves. A two-bit mode field decides how the halves work together. They can run as two separate 8-bit interval timers. The low half can instead produce an 8-bit PWM while the high half keeps timing. The halves can also chain into one 16-bit interval timer. In the last mode they form one PWM whose period spans 2^W counts, where W is programmable from 9 to 16.

The counter advances on a clock-enable strobe. In the two byte-wise modes it always takes the once-per-cycle strobe (`tick_en`). In the two chained modes a fine-rate control bit can switch it to the twice-per-cycle strobe (`half_en`). Software programs the block through a small byte write port. Each half reports its wrap event on its own sticky flag. Duty values are staged, and the compare logic only takes them up at the start of a PWM period.

Top module: `vpwm_timer`

## Requirements
- R1: After reset `pwm_out`, `irq_lo` and `irq_hi` are 0, the counter is 0 and every register is 0.
- R2: Writing address 0 loads the control byte: bits [1:0] mode (0 split, 1 timer+PWM, 2 chained timer, 3 variable PWM), bit 2 run, bit 3 fine rate, bits [7:4] width code. Addresses 1/2 hold the low/high limit byte, 3/4 the low/high duty byte, and 5 clears flags (bit 0 low, bit 1 high).
- R3: In mode 0 each half counts 0..its limit byte, then returns to 0 and sets its own flag, so an event occurs every limit+1 steps.
- R4: In mode 1 the low half counts freely over 256 steps and `pwm_out` is 1 while the low count is below the active duty low byte. Each low wrap sets `irq_lo`. The high half behaves as in mode 0.
- R5: In mode 2 the 16-bit count runs 0..{limit high, limit low}, and each wrap sets `irq_hi`. `irq_lo` is never set in this mode.
- R6: In mode 3 the period is 2^W steps with W = min(9 + width code, 16). `pwm_out` is 1 while the 16-bit count is below the 16-bit active duty. Each wrap sets `irq_hi`.
- R7: A count step occurs only when run is 1. In modes 0/1 it occurs on `tick_en`. In modes 2/3 it occurs on `half_en` if the fine bit is 1, and on `tick_en` otherwise.
- R8: Duty writes go to a staging register. The active duty copies it only at a period start (a low wrap in mode 1, a full wrap in mode 3) or on a control write.
- R9: An active duty of 0 keeps `pwm_out` at 0 for the whole period.
- R10: Flags are sticky until cleared through address 5. A new event in the same cycle wins over a clear.
- R11: A control write clears the counter and suppresses events in that cycle.
- R12: With run at 0 the counter holds, so no flag is set and `pwm_out` keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One strobe per count cycle |
| half_en | input | 1 | Two strobes per count cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | PWM output |
| irq_lo | output | 1 | Sticky low-half event flag |
| irq_hi | output | 1 | Sticky high-half / wrap event flag |

## Verification
The assertions check a set of rules on every cycle. Strobe selection is checked in the byte-wise modes. A halted or restarted counter is checked, and so is the mode-3 count bound. They also check that the active duty holds between period starts, that a zero duty keeps the output low, that flags are sticky, and that mode 2 never raises the low flag. Only the bench scenarios can show the actual periods, the high-time ratios for a given duty, and the chained carry from low to high half. They also show how a mid-period duty write lands at the next period, and that the fine bit really doubles the rate in the chained modes while it is ignored in the split modes.

// File: rtl/vpwm_pkg.sv
package vpwm_pkg;

  typedef enum logic [1:0] {
    MD_SPLIT   = 2'd0,
    MD_TMR_PWM = 2'd1,
    MD_WIDE    = 2'd2,
    MD_VPWM    = 2'd3
  } mode_e;

  typedef struct packed {
    logic [3:0] wcode;
    logic       fine;
    logic       run;
    mode_e      mode;
  } ctrl_t;

  localparam int unsigned A_CTRL    = 0;
  localparam int unsigned A_LIM_LO  = 1;
  localparam int unsigned A_LIM_HI  = 2;
  localparam int unsigned A_DUTY_LO = 3;
  localparam int unsigned A_DUTY_HI = 4;
  localparam int unsigned A_FLAGCLR = 5;

  localparam int unsigned NFLAG = 2;

endpackage

// File: rtl/vpwm_regs.sv
module vpwm_regs
  import vpwm_pkg::*;
#(
  parameter int unsigned BW = 8,
  parameter int unsigned AW = 3,
  localparam int unsigned CW = 2 * BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BW-1:0]     wr_data,
  output ctrl_t             ctrl,
  output logic [CW-1:0]     lim,
  output logic [CW-1:0]     duty_sh,
  output logic              ctrl_wr,
  output logic [NFLAG-1:0]  clr
);

  function automatic logic hit(input logic [AW-1:0] a, input int unsigned k);
    return a == AW'(k);
  endfunction

  assign ctrl_wr = wr_en && hit(wr_addr, A_CTRL);
  assign clr     = (wr_en && hit(wr_addr, A_FLAGCLR)) ? wr_data[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      lim     <= '0;
      duty_sh <= '0;
    end else if (wr_en) begin
      if (hit(wr_addr, A_CTRL))    ctrl          <= ctrl_t'(wr_data[7:0]);
      if (hit(wr_addr, A_LIM_LO))  lim[BW-1:0]   <= wr_data;
      if (hit(wr_addr, A_LIM_HI))  lim[CW-1:BW]  <= wr_data;
      if (hit(wr_addr, A_DUTY_LO)) duty_sh[BW-1:0]  <= wr_data;
      if (hit(wr_addr, A_DUTY_HI)) duty_sh[CW-1:BW] <= wr_data;
    end
  end

endmodule

// File: rtl/vpwm_count.sv
module vpwm_count
  import vpwm_pkg::*;
#(
  parameter int unsigned BW     = 8,
  parameter int unsigned MIN_PW = 9,
  localparam int unsigned CW    = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic [CW-1:0] lim,
  input  logic          step,
  input  logic          restart,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] span,
  output logic          lo_evt,
  output logic          hi_evt,
  output logic          period_start
);

  // Last count of a variable-width period: 2^W - 1, W saturating at CW.
  function automatic logic [CW-1:0] span_mask(input logic [3:0] code);
    int w;
    w = int'(MIN_PW) + int'(code);
    if (w > int'(CW)) w = int'(CW);
    return {CW{1'b1}} >> (int'(CW) - w);
  endfunction

  // One byte-wide interval step: wraps to zero past its limit.
  function automatic logic [BW-1:0] byte_next(input logic [BW-1:0] c,
                                               input logic [BW-1:0] l);
    return (c == l) ? '0 : c + BW'(1);
  endfunction

  logic [BW-1:0] c_lo, c_hi, l_lo, l_hi;
  logic [CW-1:0] nxt;

  assign c_lo = cnt[BW-1:0];
  assign c_hi = cnt[CW-1:BW];
  assign l_lo = lim[BW-1:0];
  assign l_hi = lim[CW-1:BW];
  assign span = span_mask(ctrl.wcode);

  always_comb begin
    nxt          = cnt;
    lo_evt       = 1'b0;
    hi_evt       = 1'b0;
    period_start = 1'b0;
    if (restart) begin
      nxt = '0;
    end else if (step) begin
      unique case (ctrl.mode)
        MD_SPLIT: begin
          nxt    = {byte_next(c_hi, l_hi), byte_next(c_lo, l_lo)};
          lo_evt = (c_lo == l_lo);
          hi_evt = (c_hi == l_hi);
        end
        MD_TMR_PWM: begin
          nxt          = {byte_next(c_hi, l_hi), byte_next(c_lo, {BW{1'b1}})};
          lo_evt       = (c_lo == {BW{1'b1}});
          period_start = lo_evt;
          hi_evt       = (c_hi == l_hi);
        end
        MD_WIDE: begin
          hi_evt = (cnt == lim);
          nxt    = hi_evt ? '0 : cnt + CW'(1);
        end
        MD_VPWM: begin
          hi_evt       = (cnt == span);
          period_start = hi_evt;
          nxt          = hi_evt ? '0 : cnt + CW'(1);
        end
        default: nxt = cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end

endmodule

// File: rtl/vpwm_pwm.sv
module vpwm_pwm
  import vpwm_pkg::*;
#(
  parameter int unsigned BW = 8,
  localparam int unsigned CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] duty_sh,
  input  logic          load,
  output logic [CW-1:0] duty_act,
  output logic          pwm_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    duty_act <= '0;
    else if (load) duty_act <= duty_sh;
  end

  always_comb begin
    unique case (ctrl.mode)
      MD_TMR_PWM: pwm_out = cnt[BW-1:0] < duty_act[BW-1:0];
      MD_VPWM:    pwm_out = cnt < duty_act;
      default:    pwm_out = 1'b0;
    endcase
  end

endmodule

// File: rtl/vpwm_flags.sv
module vpwm_flags
  import vpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set,
  input  logic [NFLAG-1:0] clr,
  output logic [NFLAG-1:0] flag
);

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (clr[i]) flag[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/vpwm_timer.sv
module vpwm_timer
  import vpwm_pkg::*;
#(
  parameter int unsigned BW     = 8,
  parameter int unsigned AW     = 3,
  parameter int unsigned MIN_PW = 9,
  localparam int unsigned CW    = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          half_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_data,
  output logic          pwm_out,
  output logic          irq_lo,
  output logic          irq_hi
);

  ctrl_t            ctrl;
  logic [CW-1:0]    lim, duty_sh, duty_act, cnt, span;
  logic             ctrl_wr, step, use_half;
  logic             lo_evt, hi_evt, period_start;
  logic [NFLAG-1:0] clr, flag;

  // Fine rate only applies to the chained modes (mode bit 1 set).
  assign use_half = ctrl.mode[1] & ctrl.fine;
  assign step     = ctrl.run & (use_half ? half_en : tick_en);

  vpwm_regs #(.BW(BW), .AW(AW)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .ctrl, .lim, .duty_sh, .ctrl_wr, .clr
  );

  vpwm_count #(.BW(BW), .MIN_PW(MIN_PW)) u_count (
    .clk, .rst_n, .ctrl, .lim, .step, .restart(ctrl_wr),
    .cnt, .span, .lo_evt, .hi_evt, .period_start
  );

  vpwm_pwm #(.BW(BW)) u_pwm (
    .clk, .rst_n, .ctrl, .cnt, .duty_sh,
    .load(ctrl_wr | period_start), .duty_act, .pwm_out
  );

  vpwm_flags u_flags (
    .clk, .rst_n, .set({hi_evt, lo_evt}), .clr, .flag
  );

  assign irq_lo = flag[0];
  assign irq_hi = flag[1];

endmodule

// File: rtl/vpwm_timer_chk.sv
module vpwm_timer_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic [1:0]    mode,
  input logic          run,
  input logic          step,
  input logic          ctrl_wr,
  input logic [1:0]    clr,
  input logic          lo_evt,
  input logic          hi_evt,
  input logic          period_start,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] span,
  input logic [CW-1:0] duty_act,
  input logic          pwm_out,
  input logic          irq_lo,
  input logic          irq_hi
);

  p_rate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !mode[1]) |-> tick_en);

  p_halt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ctrl_wr) |=> $stable(cnt));

  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (cnt == '0));

  p_lo_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lo_evt |=> irq_lo);

  p_hi_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hi_evt |=> irq_hi);

  p_lo_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo && !clr[0]) |=> irq_lo);

  p_hi_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hi && !clr[1]) |=> irq_hi);

  p_no_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> !lo_evt);

  p_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (cnt <= span));

  p_duty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !period_start) |=> $stable(duty_act));

  p_zero_duty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == '0) |-> !pwm_out);

endmodule

bind vpwm_timer vpwm_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode(ctrl.mode),
  .run(ctrl.run), .step(step), .ctrl_wr(ctrl_wr), .clr(clr),
  .lo_evt(lo_evt), .hi_evt(hi_evt), .period_start(period_start),
  .cnt(cnt), .span(span), .duty_act(duty_act), .pwm_out(pwm_out),
  .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/tb_vpwm_timer.sv
`timescale 1ns/1ps
module tb_vpwm_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0, half_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out, irq_lo, irq_hi;

  always #2.5 clk = ~clk;

  vpwm_timer dut (
    .clk, .rst_n, .tick_en, .half_en, .wr_en, .wr_addr, .wr_data,
    .pwm_out, .irq_lo, .irq_hi
  );

  int errors = 0, checks = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Strobes: one count cycle = 4 clocks; tick on phase 0, half on phases 0 and 2.
  int phase = 0;
  always @(negedge clk) begin
    phase   = (phase + 1) % 4;
    tick_en = (phase == 0);
    half_en = (phase == 0) || (phase == 2);
  end

  // Behavioural reference model.
  int m_mode = 0, m_run = 0, m_fine = 0, m_wcode = 0;
  int m_lim = 0, m_dsh = 0, m_dact = 0, m_cnt = 0;
  int m_flo = 0, m_fhi = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_run = 0; m_fine = 0; m_wcode = 0;
      m_lim = 0; m_dsh = 0; m_dact = 0; m_cnt = 0; m_flo = 0; m_fhi = 0;
    end else begin
      int lo, hi, w, elo, ehi;
      bit stp;
      elo = 0; ehi = 0;
      stp = m_run != 0 && ((m_mode >= 2 && m_fine != 0) ? half_en : tick_en);
      if (wr_en && wr_addr == 0) begin
        m_mode = wr_data & 3; m_run = (wr_data >> 2) & 1;
        m_fine = (wr_data >> 3) & 1; m_wcode = (wr_data >> 4) & 15;
        m_cnt = 0; m_dact = m_dsh;
      end else if (stp) begin
        lo = m_cnt % 256; hi = m_cnt / 256;
        case (m_mode)
          0, 1: begin
            if (lo == ((m_mode == 1) ? 255 : m_lim % 256)) begin
              lo = 0; elo = 1;
              if (m_mode == 1) m_dact = m_dsh;
            end else lo++;
            if (hi == m_lim / 256) begin hi = 0; ehi = 1; end else hi++;
            m_cnt = hi * 256 + lo;
          end
          2: if (m_cnt == m_lim) begin m_cnt = 0; ehi = 1; end else m_cnt++;
          default: begin
            w = 9 + m_wcode; if (w > 16) w = 16;
            if (m_cnt == (1 << w) - 1) begin m_cnt = 0; ehi = 1; m_dact = m_dsh; end
            else m_cnt++;
          end
        endcase
      end
      if (wr_en) case (wr_addr)
        1: m_lim = (m_lim & 16'hFF00) | wr_data;
        2: m_lim = (m_lim & 16'h00FF) | (wr_data << 8);
        3: m_dsh = (m_dsh & 16'hFF00) | wr_data;
        4: m_dsh = (m_dsh & 16'h00FF) | (wr_data << 8);
        default: ;
      endcase
      if (elo) m_flo = 1; else if (wr_en && wr_addr == 5 && wr_data[0]) m_flo = 0;
      if (ehi) m_fhi = 1; else if (wr_en && wr_addr == 5 && wr_data[1]) m_fhi = 0;
    end
  end

  function automatic int exp_pwm();
    if (m_mode == 1) return ((m_cnt % 256) < (m_dact % 256)) ? 1 : 0;
    if (m_mode == 3) return (m_cnt < m_dact) ? 1 : 0;
    return 0;
  endfunction

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) if (!done) begin
    check(pwm_out == exp_pwm(), {cur_req, " pwm_out"}, pwm_out, exp_pwm());
    check(irq_lo == m_flo,      {cur_req, " irq_lo"},  irq_lo,  m_flo);
    check(irq_hi == m_fhi,      {cur_req, " irq_hi"},  irq_hi,  m_fhi);
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int highs, lo_seen;
    idle(3);
    // R1: reset state
    check(pwm_out == 0 && irq_lo == 0 && irq_hi == 0, "R1 reset outputs",
          {pwm_out, irq_lo, irq_hi}, 0);
    rst_n = 1'b1;
    idle(2);

    // R2/R3: split mode, limits 3 and 5
    cur_req = "R3";
    wr(1, 3); wr(2, 5); wr(0, 8'h04);
    idle(200);
    check(irq_lo == 1 && irq_hi == 1, "R3 both halves flagged", {irq_lo, irq_hi}, 3);
    cur_req = "R10";
    wr(0, 8'h00); wr(5, 3); idle(1);
    check(irq_lo == 0 && irq_hi == 0, "R10 flags cleared", {irq_lo, irq_hi}, 0);

    // R4: timer + 8-bit PWM, duty 64 -> 256 high clocks per 1024
    cur_req = "R4";
    wr(3, 64); wr(2, 10); wr(0, 8'h05);
    highs = 0;
    repeat (1024) begin @(negedge clk); highs += pwm_out; end
    check(highs == 256, "R4 high time duty 64", highs, 256);
    cur_req = "R8";
    idle(300); wr(3, 200); idle(2200);

    // R5: chained 16-bit timer, limit 0x0123, coarse rate
    cur_req = "R5";
    wr(5, 3); wr(1, 8'h23); wr(2, 8'h01); wr(0, 8'h06);
    lo_seen = 0;
    repeat (2500) begin @(negedge clk); lo_seen |= irq_lo; end
    check(lo_seen == 0 && irq_hi == 1, "R5 only high flag", {lo_seen, irq_hi}, 1);

    // R7: fine rate in chained mode, ignored in split mode
    cur_req = "R7";
    wr(5, 3); wr(0, 8'h0E); idle(1500);
    wr(1, 2); wr(2, 7); wr(0, 8'h0C); idle(120);

    // R6: variable PWM, W=9, fine rate, duty 100 -> 200 high clocks per 1024
    cur_req = "R6";
    wr(5, 3); wr(3, 100); wr(4, 0); wr(0, 8'h0F);
    highs = 0;
    repeat (1024) begin @(negedge clk); highs += pwm_out; end
    check(highs == 200, "R6 high time W=9", highs, 200);
    idle(2000);
    // W=11, duty 0x300, then a mid-period duty change (R8)
    wr(3, 0); wr(4, 3); wr(0, 8'h2F); idle(1500);
    cur_req = "R8";
    wr(4, 1); idle(7000);

    // R9: zero duty
    cur_req = "R9";
    wr(3, 0); wr(4, 0); wr(0, 8'h0F);
    highs = 0;
    repeat (1100) begin @(negedge clk); highs += pwm_out; end
    check(highs == 0, "R9 zero duty stays low", highs, 0);

    // R12: stopped counter holds level, no events
    cur_req = "R12";
    wr(5, 3); wr(3, 5); wr(0, 8'h0B);
    highs = 0; lo_seen = 0;
    repeat (400) begin @(negedge clk); highs += pwm_out; lo_seen |= irq_lo | irq_hi; end
    check(highs == 400 && lo_seen == 0, "R12 halted", highs, 400);

    // R11: restart clears count mid-period (checked by per-cycle model)
    cur_req = "R11";
    wr(0, 8'h0F); idle(300); wr(0, 8'h0F); idle(300);
    check(checks > 12, "R2 register map exercised", checks, 13);

    finish_run();
  end

endmodule